// File: doc/BRIEF.md
# Multi-Domain Power Mode Sequencer

This block is the power controller that sits beside a processor built on three separately switched supplies: the core logic, a data-engine coprocessor and the cache RAMs. Software picks a target mode through a two-bit input. The sequencer walks each domain through an ordered set of steps: clamping, holding reset, cutting or restoring the switch, waiting for power-good, and letting reset settle. It also reports the mode it has reached and whether a transition is still under way.

The data-engine domain can be dropped on its own while the core and RAMs keep running. The two deep modes need the core's standby-ready indication, which the core raises once it has parked in its wait-for-interrupt state. In retention mode the RAMs are held in retention and the other two domains are cut. In full power-down all three domains are cut. Only an external wake event brings the block back from either deep mode, and core reset stays asserted until every domain is powered and settled. When the debug keep-powered input is high at the moment a power-down starts, the sequence and its reported mode complete as normal, but no switch is opened.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the outputs are pwr_en=3'b111, iso_en=3'b000, core_rst=0, ram_retain=0, mode_status=0, busy=0, err_timeout=0. Domain bit positions in every 3-bit domain vector: bit 0 core logic, bit 1 data engine, bit 2 RAM.
- R2: From Run (mode 0), target_mode=1 raises iso_en[1] one cycle before pwr_en[1] falls. Mode then reads 1 (data engine off), with core and RAM still powered.
- R3: From mode 1, target_mode=0 sets pwr_en[1]. The block waits for pwr_good[1], then clears iso_en and reports mode 0.
- R4: target_mode 2 (retention) or 3 (full power-down) starts a deep entry only while standby_rdy is high. Without it, the block stays in its current mode and busy stays low.
- R5: Deep entry order: all clamps on, then core_rst asserted one cycle later, then the switches opened one cycle after that. No domain switch opens unless its clamp was already on.
- R6: Mode 2 leaves only pwr_en[2] set, with ram_retain=1. Mode 3 clears all of pwr_en, with ram_retain=0. While the core is unpowered, the RAM clamp iso_en[2] stays high.
- R7: A deep mode ends only on wake_evt. The wake sets pwr_en=3'b111 and clears ram_retain, while clamps and core_rst stay on until every pwr_good bit is high.
- R8: After power-good, all clamps are released and core_rst stays high for exactly 16 further cycles before mode 0 is reported.
- R9: If dbg_keep_pwr is high when a power-down starts, the sequence still completes and reports its mode, but no pwr_en bit that was set is cleared.
- R10: err_timeout is high while the block waits for power-good and the wait has lasted tmo_cycles cycles or more. It drops once the acknowledge is taken.
- R11: busy is high exactly in transitional steps and low in all four steady modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| target_mode | input | 2 | Requested mode: 0 run, 1 data engine off, 2 retention, 3 full power-down |
| standby_rdy | input | 1 | Core parked and ready for a deep mode |
| wake_evt | input | 1 | External wake from a deep mode |
| dbg_keep_pwr | input | 1 | Debug request to keep all domains powered |
| tmo_cycles | input | TMO_W | Power-good wait limit in cycles |
| pwr_good | input | 3 | Per-domain power-good acknowledge |
| pwr_en | output | 3 | Per-domain power switch enable |
| iso_en | output | 3 | Per-domain isolation clamp enable (bit 2 clamps RAM inputs, chip enable inactive) |
| ram_retain | output | 1 | RAM retention control |
| core_rst | output | 1 | Core reset, active high |
| mode_status | output | 3 | Last mode reached, encoded as target_mode |
| busy | output | 1 | Transition in progress |
| err_timeout | output | 1 | Power-good wait exceeded the limit |

## Verification
The timeout and the power-good acknowledge can land in the same cycle. At that point the wait counter reaches tmo_cycles at the same moment the acknowledge comes in, so err_timeout shows for one sample and the sequencer moves on at the next edge. The bench provokes this by sweeping the acknowledge delay across the limit. For each delay it judges whether err_timeout should appear at all: it should appear exactly when the delay is at least the limit, and it must be clear once the transition ends.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;
  localparam int NDOM     = 3;
  localparam int DOM_CORE = 0;
  localparam int DOM_DE   = 1;
  localparam int DOM_RAM  = 2;

  typedef enum logic [2:0] {
    MS_RUN      = 3'd0,
    MS_DE_OFF   = 3'd1,
    MS_RETAIN   = 3'd2,
    MS_POWEROFF = 3'd3
  } mode_e;

  typedef enum logic [3:0] {
    ST_RUN, ST_DE_ISO, ST_DE_OFF, ST_DE_ON,
    ST_DP_ISO, ST_DP_RST, ST_RETAIN, ST_POWEROFF,
    ST_UP_ON, ST_UP_SET
  } state_e;
endpackage

// File: rtl/pwrseq_cnt.sv
module pwrseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)          cnt_d = '0;
    else if (&cnt_q)  cnt_d = cnt_q;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
  import pwrseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      target_mode,
  input  logic            standby_rdy,
  input  logic            wake_evt,
  input  logic            dbg_keep_pwr,
  input  logic [NDOM-1:0] pwr_good,
  input  logic            settle_done,
  output logic            wait_ack,
  output logic            in_settle,
  output logic [NDOM-1:0] pwr_en,
  output logic [NDOM-1:0] iso_en,
  output logic            ram_retain,
  output logic            core_rst,
  output logic [2:0]      mode_status,
  output logic            busy
);
  state_e          state_q, state_d;
  logic [NDOM-1:0] pe_q, pe_d, iso_q, iso_d;
  logic            rst_q, rst_d, ret_q, ret_d, emu_q, emu_d, dorm_q, dorm_d;
  mode_e           mode_q, mode_d;
  logic            deep_req;

  assign deep_req = target_mode[1] & standby_rdy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (deep_req) state_d = ST_DP_ISO;
                   else if (target_mode == 2'd1) state_d = ST_DE_ISO;
      ST_DE_ISO:   state_d = ST_DE_OFF;
      ST_DE_OFF:   if (deep_req) state_d = ST_DP_ISO;
                   else if (target_mode == 2'd0) state_d = ST_DE_ON;
      ST_DE_ON:    if (pwr_good[DOM_DE]) state_d = ST_RUN;
      ST_DP_ISO:   state_d = ST_DP_RST;
      ST_DP_RST:   state_d = dorm_q ? ST_RETAIN : ST_POWEROFF;
      ST_RETAIN,
      ST_POWEROFF: if (wake_evt) state_d = ST_UP_ON;
      ST_UP_ON:    if (&pwr_good) state_d = ST_UP_SET;
      ST_UP_SET:   if (settle_done) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_comb begin
    pe_d = pe_q; iso_d = iso_q; rst_d = rst_q; ret_d = ret_q;
    emu_d = emu_q; dorm_d = dorm_q; mode_d = mode_q;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_DE_ISO: begin iso_d[DOM_DE] = 1'b1; emu_d = dbg_keep_pwr; end
        ST_DE_OFF: begin pe_d[DOM_DE] = pe_q[DOM_DE] & emu_q; mode_d = MS_DE_OFF; end
        ST_DE_ON:  pe_d = '1;
        ST_RUN:    begin iso_d = '0; rst_d = 1'b0; mode_d = MS_RUN; end
        ST_DP_ISO: begin iso_d = '1; emu_d = dbg_keep_pwr; dorm_d = (target_mode == 2'd2); end
        ST_DP_RST: rst_d = 1'b1;
        ST_RETAIN, ST_POWEROFF: begin
          pe_d[DOM_CORE] = pe_q[DOM_CORE] & emu_q;
          pe_d[DOM_DE]   = pe_q[DOM_DE] & emu_q;
          pe_d[DOM_RAM]  = pe_q[DOM_RAM] & (emu_q | dorm_q);
          ret_d          = dorm_q;
          mode_d         = dorm_q ? MS_RETAIN : MS_POWEROFF;
        end
        ST_UP_ON:  begin pe_d = '1; ret_d = 1'b0; end
        ST_UP_SET: iso_d = '0;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN; pe_q <= '1; iso_q <= '0; rst_q <= 1'b0; ret_q <= 1'b0;
      emu_q <= 1'b0; dorm_q <= 1'b0; mode_q <= MS_RUN;
    end else begin
      state_q <= state_d; pe_q <= pe_d; iso_q <= iso_d; rst_q <= rst_d; ret_q <= ret_d;
      emu_q <= emu_d; dorm_q <= dorm_d; mode_q <= mode_d;
    end
  end

  assign pwr_en      = pe_q;
  assign iso_en      = iso_q;
  assign ram_retain  = ret_q;
  assign core_rst    = rst_q;
  assign mode_status = mode_q;
  assign wait_ack    = (state_q == ST_DE_ON) || (state_q == ST_UP_ON);
  assign in_settle   = (state_q == ST_UP_SET);
  assign busy        = !((state_q == ST_RUN) || (state_q == ST_DE_OFF) ||
                         (state_q == ST_RETAIN) || (state_q == ST_POWEROFF));

  // A switch may only open on a domain that is already clamped.
  for (genvar d = 0; d < NDOM; d++) begin : g_dom_chk
    assert_clamp_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pe_q[d]) |-> $past(iso_q[d]));
  end

  assert_reset_before_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pe_q[DOM_CORE]) |-> $past(rst_q));

  assert_ram_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_q[DOM_CORE] |-> iso_q[DOM_RAM]);

  assert_standby_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_q[DOM_CORE]) |-> $past(standby_rdy));

  assert_good_before_unclamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_q[DOM_CORE]) |-> $past(&pwr_good));

  assert_release_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_q) |-> (pe_q == '1) && (iso_q == '0));

  assert_emulate_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_q && !busy && (mode_q == MS_RETAIN || mode_q == MS_POWEROFF))
      |-> pe_q[DOM_CORE] && pe_q[DOM_RAM]);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwrseq_pkg::*;
#(
  parameter int TMO_W      = 16,
  parameter int SETTLE_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       target_mode,
  input  logic             standby_rdy,
  input  logic             wake_evt,
  input  logic             dbg_keep_pwr,
  input  logic [TMO_W-1:0] tmo_cycles,
  input  logic [2:0]       pwr_good,
  output logic [2:0]       pwr_en,
  output logic [2:0]       iso_en,
  output logic             ram_retain,
  output logic             core_rst,
  output logic [2:0]       mode_status,
  output logic             busy,
  output logic             err_timeout
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  logic             rst_meta, rst_sync_n;
  logic             wait_ack, in_settle, settle_done;
  logic [TMO_W-1:0] tmo_cnt;
  logic [SET_W-1:0] set_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rst_meta <= 1'b0; rst_sync_n <= 1'b0; end
    else        begin rst_meta <= 1'b1; rst_sync_n <= rst_meta; end
  end

  pwrseq_cnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst_n(rst_sync_n), .en(wait_ack), .cnt(tmo_cnt));

  pwrseq_cnt #(.W(SET_W)) u_settle (
    .clk(clk), .rst_n(rst_sync_n), .en(in_settle), .cnt(set_cnt));

  assign settle_done = (set_cnt == SET_W'(SETTLE_CYC - 1));

  pwrseq_fsm u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .target_mode(target_mode),
    .standby_rdy(standby_rdy), .wake_evt(wake_evt), .dbg_keep_pwr(dbg_keep_pwr),
    .pwr_good(pwr_good), .settle_done(settle_done), .wait_ack(wait_ack),
    .in_settle(in_settle), .pwr_en(pwr_en), .iso_en(iso_en),
    .ram_retain(ram_retain), .core_rst(core_rst), .mode_status(mode_status),
    .busy(busy));

  assign err_timeout = wait_ack && (tmo_cnt >= tmo_cycles);

  assert_err_only_waiting_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_timeout |-> busy && core_rst == $past(core_rst));
endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  logic        clk, rst_n;
  logic [1:0]  target_mode;
  logic        standby_rdy, wake_evt, dbg_keep_pwr;
  logic [15:0] tmo_cycles;
  logic [2:0]  pwr_good, pwr_en, iso_en, mode_status;
  logic        ram_retain, core_rst, busy, err_timeout;

  int checks = 0, errors = 0, cyc = 0;
  int ack_dly = 3;
  logic [2:0] ack_blk = 3'b000;
  int ack_cnt [3];

  pwr_mode_seq dut (
    .clk(clk), .rst_n(rst_n), .target_mode(target_mode), .standby_rdy(standby_rdy),
    .wake_evt(wake_evt), .dbg_keep_pwr(dbg_keep_pwr), .tmo_cycles(tmo_cycles),
    .pwr_good(pwr_good), .pwr_en(pwr_en), .iso_en(iso_en), .ram_retain(ram_retain),
    .core_rst(core_rst), .mode_status(mode_status), .busy(busy), .err_timeout(err_timeout));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Power switch model: acknowledge follows enable after ack_dly cycles.
  always @(negedge clk) begin
    for (int d = 0; d < 3; d++) begin
      if (!pwr_en[d]) begin ack_cnt[d] = 0; pwr_good[d] = 1'b0; end
      else if (!ack_blk[d]) begin
        if (ack_cnt[d] >= ack_dly) pwr_good[d] = 1'b1;
        else ack_cnt[d]++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  function automatic logic [2:0] exp_iso(input int m);
    case (m)
      0: return 3'b000;
      1: return 3'b010;
      default: return 3'b111;
    endcase
  endfunction

  task automatic wake_up();
    target_mode = 2'd0; standby_rdy = 1'b0; wake_evt = 1'b1;
    step(1); wake_evt = 1'b0;
    wait_idle();
  endtask

  initial begin
    int m;
    logic [2:0] mpe;
    logic mret, seen;
    void'($urandom(32'h5eed1234));
    rst_n = 1'b0; target_mode = 2'd0; standby_rdy = 1'b0; wake_evt = 1'b0;
    dbg_keep_pwr = 1'b0; tmo_cycles = 16'd20; pwr_good = 3'b000;
    step(3); rst_n = 1'b1; step(8);

    // R1 reset state
    chk({5'd0, pwr_en}, 8'h07, "R1 pwr_en");
    chk({5'd0, iso_en}, 8'h00, "R1 iso_en");
    chk({core_rst, ram_retain, busy, err_timeout, 1'b0, mode_status}, 8'h00, "R1 flags");

    // R2 data engine off
    target_mode = 2'd1; step(1);
    chk({5'd0, iso_en}, 8'h02, "R2 clamp first");
    chk({5'd0, pwr_en}, 8'h07, "R2 still on");
    chk({7'd0, busy}, 8'h01, "R11 busy in step");
    step(1);
    chk({5'd0, pwr_en}, 8'h05, "R2 de off");
    chk({5'd0, mode_status}, 8'h01, "R2 mode");
    chk({7'd0, busy}, 8'h00, "R11 idle steady");

    // R3 data engine back on
    target_mode = 2'd0; step(1);
    chk({5'd0, pwr_en}, 8'h07, "R3 switch on");
    chk({5'd0, iso_en}, 8'h02, "R3 clamp held");
    wait_idle();
    chk({5'd0, iso_en}, 8'h00, "R3 unclamp");
    chk({5'd0, mode_status}, 8'h00, "R3 mode");

    // R4 no deep entry without standby
    target_mode = 2'd2; standby_rdy = 1'b0; step(6);
    chk({busy, 4'd0, mode_status}, 8'h00, "R4 gated");
    chk({5'd0, iso_en}, 8'h00, "R4 no clamp");

    // R5/R6 retention entry
    standby_rdy = 1'b1; step(1);
    chk({core_rst, 4'd0, iso_en}, 8'h07, "R5 clamps before reset");
    step(1);
    chk({core_rst, 4'd0, pwr_en}, 8'h87, "R5 reset before cut");
    step(1);
    chk({5'd0, pwr_en}, 8'h04, "R6 retention power");
    chk({ram_retain, busy, 3'd0, mode_status}, 8'h82, "R6 retention flags");
    target_mode = 2'd0; standby_rdy = 1'b0; step(5);
    chk({5'd0, mode_status}, 8'h02, "R7 stays without wake");

    // R7/R8 wake and settle
    wake_evt = 1'b1; step(1); wake_evt = 1'b0;
    chk({5'd0, pwr_en}, 8'h07, "R7 power on");
    chk({ram_retain, core_rst, 3'd0, iso_en}, 8'h47, "R7 clamps and reset held");
    for (int i = 0; i < 50 && iso_en != 3'b000; i++) step(1);
    begin
      int rc = 0;
      for (int i = 0; i < 50 && core_rst; i++) begin rc++; step(1); end
      chk(8'(rc), 8'd16, "R8 settle length");
    end
    chk({busy, 4'd0, mode_status}, 8'h00, "R8 back to run");

    // R6 full power-down from data-engine-off
    target_mode = 2'd1; step(2);
    target_mode = 2'd3; standby_rdy = 1'b1; wait_idle(); step(1); wait_idle();
    chk({5'd0, pwr_en}, 8'h00, "R6 all off");
    chk({ram_retain, 4'd0, mode_status}, 8'h03, "R6 power-off flags");
    wake_up();
    chk({5'd0, pwr_en}, 8'h07, "R7 wake from power-off");

    // R9 emulate
    dbg_keep_pwr = 1'b1; target_mode = 2'd3; standby_rdy = 1'b1; step(1); wait_idle();
    chk({5'd0, pwr_en}, 8'h07, "R9 kept powered");
    chk({core_rst, 4'd0, mode_status}, 8'h83, "R9 handshake done");
    wake_up(); dbg_keep_pwr = 1'b0;
    chk({core_rst, 4'd0, mode_status}, 8'h00, "R9 back to run");

    // R10 timeout sweep across the limit
    tmo_cycles = 16'd4;
    for (int dly = 0; dly < 8; dly++) begin
      ack_dly = dly;
      target_mode = 2'd1; step(2);
      target_mode = 2'd0; step(1);
      seen = 1'b0;
      for (int i = 0; i < 40 && busy; i++) begin seen |= err_timeout; step(1); end
      chk({7'd0, seen}, {7'd0, dly >= 4}, "R10 err seen");
      chk({7'd0, err_timeout}, 8'h00, "R10 err clear after");
    end
    // R10 blocked acknowledge
    ack_dly = 2; ack_blk = 3'b010;
    target_mode = 2'd1; step(2); target_mode = 2'd0; step(3);
    chk({7'd0, err_timeout}, 8'h00, "R10 before limit");
    step(4);
    chk({7'd0, err_timeout}, 8'h01, "R10 after limit");
    ack_blk = 3'b000; wait_idle();
    chk({err_timeout, 4'd0, mode_status}, 8'h00, "R10 recovered");
    tmo_cycles = 16'd20;

    // Random mix against a mode model
    m = 0; mpe = 3'b111; mret = 1'b0;
    for (int it = 0; it < 40; it++) begin
      logic [1:0] t; logic sb, dbg;
      t = 2'($urandom_range(0, 3)); sb = 1'($urandom_range(0, 1));
      dbg = 1'($urandom_range(0, 1)); ack_dly = $urandom_range(0, 6);
      target_mode = t; standby_rdy = sb; dbg_keep_pwr = dbg;
      if (t >= 2 && sb) begin
        m = t; mpe[0] = dbg; mpe[1] = mpe[1] & dbg; mpe[2] = dbg | (t == 2); mret = (t == 2);
      end else if (m == 0 && t == 1) begin m = 1; mpe[1] = dbg; end
      else if (m == 1 && t == 0) begin m = 0; mpe = 3'b111; end
      step(1); wait_idle(); step(1);
      chk({5'd0, mode_status}, 8'(m), "R11 random mode");
      chk({5'd0, pwr_en}, {5'd0, mpe}, "R9 random pwr_en");
      chk({ram_retain, core_rst, busy, 2'd0, iso_en}, {mret, m >= 2, 1'b0, 2'd0, exp_iso(m)},
          "R6 random flags");
      if (m >= 2) begin
        wake_up();
        m = 0; mpe = 3'b111; mret = 1'b0;
        chk({core_rst, pwr_en, 1'b0, mode_status}, 8'h70, "R8 random wake");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule